// File: doc/BRIEF.md
# Flash Synchronous Burst Read Engine

This block is the read side of a NOR-style flash memory. After reset it answers in a simple address-to-data mode: each clock with the chip enabled, it returns the word at the presented address one clock later. A 16-bit configuration register switches it into a clocked burst mode. In that mode the host latches a start address with a strobe. The engine waits a programmable number of clocks and then streams one word per clock from an internal address counter. A ready output marks valid data.

The configuration register is written and read through a two-step command port. It holds the mode, the initial wait code, the burst type (continuous across the whole array, or wrapping inside an aligned group of 8, 16 or 32 words) and whether ready leads the data by a clock or arrives with it. The array is a computed read-only store, so the data pattern is fixed and known.

Top module: `flash_burst_rd`

## Requirements
- R1: After reset, `dout` is 0, `rdy` is 0, and the configuration register holds 0x8000, which selects the address-to-data mode.
- R2: Command 0x00C5 on `cmd_data` with `cmd_wr` high arms a load. The next `cmd_wr` cycle loads `cmd_data` into the configuration register. Command 0x00C6 makes the next clock that has `ce_n` and `lat_n` both low return the register on `dout` with `rdy` high for one clock. That clock starts no burst.
- R3: Command cycles taken while `ce_n` is low are ignored. With nothing armed, codes other than 0x00C5 and 0x00C6 are ignored.
- R4: With bit 15 of the configuration register at 1, every clock edge with `ce_n` low loads the word at `addr` into `dout` and sets `rdy`. `lat_n` is ignored.
- R5: With bit 15 at 0, an edge with `ce_n` and `lat_n` both low latches `addr`. Let n be bits 13:11. The first word, taken from the latched address, appears on `dout` after the (n+2)th edge following the latch edge. `dout` stays 0 before that.
- R6: After the first word, each further edge delivers the next word, with `rdy` held high.
- R7: With bit 3 at 0 (continuous), successive addresses count up by one and wrap from the top address to 0.
- R8: With bit 3 at 1 (linear), addresses count up inside the aligned group that holds the start address. The group is 8 words when bits 1:0 are 00, 16 when 01, and 32 otherwise.
- R9: With bit 10 at 0, `rdy` rises in the same clock as the first word. With bit 10 at 1, it rises one clock earlier.
- R10: An edge with `ce_n` high ends any burst and sets `dout` and `rdy` to 0. They stay 0 until a new latch or a new address-to-data read.
- R11: A latch during a burst abandons it and starts a new burst from the new address.
- R12: The word stored at address a is the low 16 bits of (a × 257) XOR 0x5A3C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| lat_n | input | 1 | Address latch strobe, active low |
| addr | input | ADDR_W | Word address |
| cmd_wr | input | 1 | Command write cycle |
| cmd_data | input | 16 | Command code or register value |
| dout | output | 16 | Read data, 0 when not valid |
| rdy | output | 1 | Data-valid indicator |

## Verification
A wrong wait counter shifts the whole burst. The first compared clock after the intended data slot shows a zero word or an early word. A wrong address counter or wrap mask shows up as a wrong word on the first beat that crosses a group or array boundary, so each wrap case is started just below its edge. A stale configuration or command state shows on the next read-back or the next latch. A reference model compares `dout` and `rdy` on every clock, so the error is reported in the cycle it first reaches the pins.

// File: rtl/flash_burst_pkg.sv
package flash_burst_pkg;
    localparam int          DATA_W         = 16;
    localparam logic [15:0] CMD_CFG_WR     = 16'h00C5;
    localparam logic [15:0] CMD_CFG_RD     = 16'h00C6;
    localparam logic [15:0] CFG_RESET      = 16'h8000;
    localparam logic [15:0] WORD_SEED      = 16'h5A3C;
    localparam int          CFG_MODE_BIT   = 15;
    localparam int          CFG_WAIT_LO    = 11;
    localparam int          CFG_EARLY_BIT  = 10;
    localparam int          CFG_LINEAR_BIT = 3;

    typedef enum logic {
        ST_IDLE,
        ST_BURST
    } rd_state_e;
endpackage

// File: rtl/flash_cfg_port.sv
module flash_cfg_port
    import flash_burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              cmd_wr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              rd_take,
    output logic [DATA_W-1:0] cfg,
    output logic              rd_pend
);
    typedef struct packed {
        logic [DATA_W-1:0] cfg;
        logic              armed;
        logic              pend;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_wr && ce_n) begin
            if (st_q.armed) begin
                st_d.cfg   = cmd_data;
                st_d.armed = 1'b0;
            end else if (cmd_data == CMD_CFG_WR) begin
                st_d.armed = 1'b1;
            end else if (cmd_data == CMD_CFG_RD) begin
                st_d.pend = 1'b1;
            end
        end
        if (rd_take) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg   <= CFG_RESET;
            st_q.armed <= 1'b0;
            st_q.pend  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg     = st_q.cfg;
    assign rd_pend = st_q.pend;

    AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> ($stable(st_q.cfg) && $stable(st_q.armed)));  // R3
endmodule

// File: rtl/flash_word_rom.sv
module flash_word_rom
    import flash_burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] word
);
    localparam int PROD_W = ADDR_W + 10;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(addr) * PROD_W'(257);
        word = prod[DATA_W-1:0] ^ WORD_SEED;
    end
endmodule

// File: rtl/flash_next_addr.sv
module flash_next_addr #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic              linear,
    input  logic [1:0]        wrap_sel,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] inc;

    always_comb begin
        case (wrap_sel)
            2'b00:   mask = ADDR_W'(7);
            2'b01:   mask = ADDR_W'(15);
            default: mask = ADDR_W'(31);
        endcase
        inc = cur + ONE;
        nxt = linear ? ((cur & ~mask) | (inc & mask)) : inc;
    end
endmodule

// File: rtl/flash_burst_rd.sv
module flash_burst_rd
    import flash_burst_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              lat_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cmd_wr,
    input  logic [15:0]       cmd_data,
    output logic [15:0]       dout,
    output logic              rdy
);
    localparam int CNT_W = 4;

    typedef struct packed {
        rd_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              linear;
        logic [1:0]        wrap_sel;
        logic              early;
        logic [DATA_W-1:0] dout;
        logic              rdy;
    } rd_st_t;

    rd_st_t st_d, st_q;

    logic [DATA_W-1:0] cfg;
    logic              rd_pend;
    logic              rd_take;
    logic [ADDR_W-1:0] rom_addr;
    logic [DATA_W-1:0] rom_word;
    logic [ADDR_W-1:0] nxt_addr;
    logic              loading;

    flash_cfg_port u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .cmd_wr   (cmd_wr),
        .cmd_data (cmd_data),
        .rd_take  (rd_take),
        .cfg      (cfg),
        .rd_pend  (rd_pend)
    );

    assign rom_addr = cfg[CFG_MODE_BIT] ? addr : st_q.addr;

    flash_word_rom #(.ADDR_W(ADDR_W)) u_rom (
        .addr (rom_addr),
        .word (rom_word)
    );

    flash_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur      (st_q.addr),
        .linear   (st_q.linear),
        .wrap_sel (st_q.wrap_sel),
        .nxt      (nxt_addr)
    );

    assign loading = (st_q.state == ST_BURST) && (st_q.cnt == '0);

    always_comb begin
        st_d      = st_q;
        st_d.dout = '0;
        st_d.rdy  = 1'b0;
        rd_take   = 1'b0;
        if (ce_n) begin
            st_d.state = ST_IDLE;
        end else if (!lat_n && rd_pend) begin
            st_d.dout  = cfg;
            st_d.rdy   = 1'b1;
            st_d.state = ST_IDLE;
            rd_take    = 1'b1;
        end else if (cfg[CFG_MODE_BIT]) begin
            st_d.dout  = rom_word;
            st_d.rdy   = 1'b1;
            st_d.state = ST_IDLE;
        end else if (!lat_n) begin
            st_d.state    = ST_BURST;
            st_d.cnt      = CNT_W'(cfg[CFG_WAIT_LO +: 3]) + CNT_W'(1);
            st_d.addr     = addr;
            st_d.linear   = cfg[CFG_LINEAR_BIT];
            st_d.wrap_sel = cfg[1:0];
            st_d.early    = cfg[CFG_EARLY_BIT];
        end else if (st_q.state == ST_BURST) begin
            if (!loading) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
                st_d.rdy = st_q.early && (st_q.cnt == CNT_W'(1));
            end else begin
                st_d.dout = rom_word;
                st_d.rdy  = 1'b1;
                st_d.addr = nxt_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, cnt: '0, addr: '0, linear: 1'b0,
                      wrap_sel: 2'b00, early: 1'b0, dout: '0, rdy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.dout;
    assign rdy  = st_q.rdy;

    AST_CE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> (!rdy && dout == '0));  // R10
    AST_WAIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_BURST && st_q.cnt != '0 && !ce_n && lat_n && !cfg[CFG_MODE_BIT])
        |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));  // R5
    AST_STREAM_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && !ce_n && lat_n && !cfg[CFG_MODE_BIT]) |=> rdy);  // R6
    AST_LINEAR_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (loading && st_q.linear && !ce_n && lat_n && !cfg[CFG_MODE_BIT])
        |=> (((st_q.addr ^ $past(st_q.addr)) >> 5) == '0));  // R8
endmodule

// File: tb/flash_burst_rd_tb.sv
module flash_burst_rd_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          lat_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cmd_wr = 1'b0;
    logic [15:0]   cmd_data = '0;
    logic [15:0]   dout;
    logic          rdy;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    checking = 0;
    string cur_req  = "R1";

    // reference model state
    int m_cfg, m_pend, m_armed, m_busy, m_start, m_el, m_wait, m_lin, m_wsel, m_early;
    int exp_d, exp_r;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_burst_rd #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .lat_n(lat_n), .addr(addr),
        .cmd_wr(cmd_wr), .cmd_data(cmd_data), .dout(dout), .rdy(rdy)
    );

    function automatic int word_at(int a);  // R12
        return ((a * 257) ^ 'h5A3C) & 'hFFFF;
    endfunction

    function automatic int burst_addr(int start, int j, int lin, int wsel);
        int len;
        if (lin == 0) return (start + j) % 256;  // R7
        len = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;  // R8
        return (start - start % len) + ((start % len + j) % len);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 'h8000; m_pend = 0; m_armed = 0; m_busy = 0;
            exp_d = 0; exp_r = 0;
        end else begin
            if (cmd_wr && ce_n) begin
                if (m_armed != 0) begin m_cfg = cmd_data; m_armed = 0; end
                else if (cmd_data == 16'h00C5) m_armed = 1;
                else if (cmd_data == 16'h00C6) m_pend = 1;
            end
            exp_d = 0; exp_r = 0;
            if (ce_n) begin
                m_busy = 0;
            end else if (!lat_n && m_pend != 0) begin
                exp_d = m_cfg; exp_r = 1; m_pend = 0; m_busy = 0;
            end else if (m_cfg[15]) begin
                exp_d = word_at(addr); exp_r = 1; m_busy = 0;
            end else if (!lat_n) begin
                m_busy = 1; m_start = addr; m_el = 0;
                m_wait = (m_cfg >> 11) & 7; m_lin = m_cfg[3];
                m_wsel = m_cfg & 3; m_early = m_cfg[10];
            end else if (m_busy != 0) begin
                m_el++;
                if (m_el >= m_wait + 2) begin
                    exp_d = word_at(burst_addr(m_start, m_el - m_wait - 2, m_lin, m_wsel));
                    exp_r = 1;
                end else if (m_early != 0 && m_el == m_wait + 1) begin
                    exp_r = 1;  // R9
                end
            end
        end
    end

    always @(negedge clk) begin
        if (checking) begin
            n_checks++;
            if (dout !== 16'(exp_d) || rdy !== exp_r[0]) begin
                n_fail++;
                $display("FAIL %s cycle %0d: dout=%h rdy=%b expected dout=%h rdy=%b",
                         cur_req, cycles, dout, rdy, 16'(exp_d), exp_r[0]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic step(input bit ce, input bit lt, input int a, input bit w, input int d);
        @(negedge clk);
        ce_n = ce; lat_n = lt; addr = AW'(a); cmd_wr = w; cmd_data = 16'(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0);
    endtask

    task automatic cfg_write(input int v);
        step(1, 1, 0, 1, 'h00C5);
        step(1, 1, 0, 1, v);
        idle(1);
    endtask

    task automatic cfg_read();
        step(1, 1, 0, 1, 'h00C6);
        step(0, 0, 0, 0, 0);
        idle(2);
    endtask

    task automatic burst(input int a, input int n);
        step(0, 0, a, 0, 0);
        for (int i = 0; i < n; i++) step(0, 1, 'hAA, 0, 0);
        idle(1);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1; checking = 1;
        cur_req = "R1"; idle(2);
        cfg_read();                          // R1 reset value 0x8000
        cur_req = "R4";
        for (int i = 0; i < 4; i++) step(0, i % 2, (i * 77 + 3) % 256, 0, 0);
        step(0, 1, 'hFF, 0, 0); idle(1);
        cur_req = "R12";
        step(0, 0, 0, 0, 0); step(0, 1, 1, 0, 0); step(0, 1, 'h80, 0, 0); idle(1);
        cur_req = "R3";
        step(1, 1, 0, 1, 'h1234);
        step(0, 1, 5, 1, 'h00C5); step(0, 1, 6, 1, 'h0000); idle(1);
        cfg_read();
        step(0, 1, 9, 0, 0); idle(1);
        cur_req = "R2";
        cfg_write('h1000); cfg_read();
        cur_req = "R5"; burst('h20, 10);
        cur_req = "R7"; burst('hFC, 10);
        cur_req = "R9 R8";
        cfg_write('h0408); burst('h0D, 12);
        cur_req = "R8";
        cfg_write('h3809); burst('h37, 27);
        cfg_write('h2C0A); burst('h5E, 40);
        cfg_write('h0403); burst('hE3, 36);
        cur_req = "R10";
        cfg_write('h0800);
        step(0, 0, 'h40, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0);
        idle(2);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0);
        idle(1);
        cur_req = "R11";
        step(0, 0, 'h10, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 1, 0, 0, 0);
        burst('h90, 8);
        cur_req = "R6";
        cfg_write('h0000); burst('h33, 8);
        cur_req = "R2"; cfg_read();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule